// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is an up-counter that shapes a repeating pulse from two compare values: a period value that sets how many count clocks one cycle lasts, and a duty value that sets how long the output stays active within each cycle. The counter only moves on cycles where an external count-enable strobe is high. That strobe comes from a prescaler outside the block. Software programs the block through a plain single-cycle register write strobe and a combinational read port.

The output flip-flop toggles on the period match and, when enabled, on the duty match. Software can also force it high or low with write-only strobe bits. A self-clearing trigger bit starts a single counting pass when the block is in one-shot mode. An independent edge detector watches an external input and raises a one-cycle pulse on rising, falling or both edges. The block produces three one-cycle interrupt request pulses: period match, duty match and input edge.

Register map (address on `wr_addr`/`rd_addr`):
- 0 control: bit0 run, bit1 one-shot mode, bits3:2 edge select (0 off, 1 rising, 2 falling, 3 both).
- 1 period value.
- 2 duty value.
- 3 output control: bit0 output enable, bit1 toggle on period match, bit2 toggle on duty match, bit3 force-high strobe, bit4 force-low strobe, bit5 one-shot trigger.
- 4 duty interrupt: bit0 mask; bit1 reads the duty-match flag, and writing 1 to it clears the flag.

Top module: `ppg_timer`

## Requirements
- R1: While running in periodic mode, the counter steps 0,1,…,P on each count-enable cycle and returns to 0 after P, so one cycle lasts P+1 count clocks. `per_irq_o` pulses for one clock in the cycle where the counter has just returned to 0. P may be as large as the counter's full range.
- R2: With both toggle bits set and the output first forced high, `ppg_o` is high while the counter is at 0..D and low for the rest of the cycle, so it is high for D+1 count clocks of every P+1. D=0 is valid. Settings must satisfy D < P.
- R3: The counter changes only after cycles in which `cnt_tick_i` was high. Clearing run returns the counter to 0 and holds it there.
- R4: With the duty-toggle bit (output control bit2) clear, the output changes only where the counter wraps to 0, so the duty value can be rewritten without a stray edge.
- R5: `duty_irq_o` pulses for one clock when the counter has just left the duty value (it reads D+1). Setting the mask bit suppresses the pulse, but the flag at interrupt bit1 is still set. Writing 1 to bit1 clears the flag.
- R6: In one-shot mode the counter waits at 0 until the trigger bit is written. It then makes exactly one pass 0..P with one `per_irq_o` pulse and stops at 0. The trigger bit reads as 0.
- R7: A trigger write while one-shot mode is off has no effect: after a later switch into one-shot mode, the counter does not advance.
- R8: Force-high sets the output flip-flop and force-low clears it, with force-low taking priority. Both bits read back as 0.
- R9: Force-high is accepted only if output enable was already set before the write. A single write that sets output enable and force-high together leaves the output low.
- R10: The edge pulse `edge_irq_o` follows the selected mode: rising only, falling only, both, or none.
- R11: If the edge input is high when the timer is enabled for the first time after reset, one rising edge is reported at once. Re-enabling after a stop with the input still high reports nothing.
- R12: `ppg_o` is low whenever output enable is clear, and the flip-flop keeps its state, which shows again once enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| cnt_tick_i | input | 1 | Count-clock enable from the prescaler |
| edge_in_i | input | 1 | External edge input (synchronised inside) |
| cnt_o | output | CNT_W | Current counter value |
| ppg_o | output | 1 | Pulse output |
| per_irq_o | output | 1 | Period-match request pulse |
| duty_irq_o | output | 1 | Duty-match request pulse |
| edge_irq_o | output | 1 | Input-edge request pulse |

## Verification
The bench builds the block with an 8-bit counter and a two-stage input synchroniser. The narrow counter brings the full-range period of 255 within reach: one complete cycle of 256 count clocks, with its wrap and the matching output duty, fits in a short run. The two-stage synchroniser is the default and places the edge pulse three clocks after an input change. This checks the first-enable behaviour against real synchroniser latency. A divided count strobe (one tick in three) shows that the counter's pace comes from the strobe and not from the clock.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_DUTY   = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUTCTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ    = 3'd4;

  // control register fields
  localparam int CB_RUN  = 0;
  localparam int CB_OS   = 1;
  localparam int CB_EDGE = 2;
  // output control fields
  localparam int OB_EN   = 0;
  localparam int OB_PINV = 1;
  localparam int OB_DINV = 2;
  localparam int OB_SET  = 3;
  localparam int OB_CLR  = 4;
  localparam int OB_TRIG = 5;
  // duty interrupt fields
  localparam int IB_MASK = 0;
  localparam int IB_FLAG = 1;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic out_en;
    logic per_inv;
    logic duty_inv;
  } out_ctl_t;
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              duty_hit_i,
  output logic              run_o,
  output logic              os_mode_o,
  output edge_sel_e         edge_sel_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  duty_o,
  output out_ctl_t          octl_o,
  output logic              duty_mask_o,
  output logic              lvl_set_o,
  output logic              lvl_clr_o,
  output logic              os_trig_o
);
  logic             run_q, os_q, mask_q, flag_q;
  edge_sel_e        edge_q;
  logic [CNT_W-1:0] period_q, duty_q;
  out_ctl_t         octl_q;

  logic wr_ctrl, wr_per, wr_duty, wr_out, wr_irq;
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_per  = wr_en_i && (wr_addr_i == A_PERIOD);
  assign wr_duty = wr_en_i && (wr_addr_i == A_DUTY);
  assign wr_out  = wr_en_i && (wr_addr_i == A_OUTCTL);
  assign wr_irq  = wr_en_i && (wr_addr_i == A_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      os_q     <= 1'b0;
      edge_q   <= EDGE_OFF;
      period_q <= '1;
      duty_q   <= '0;
      octl_q   <= '0;
      mask_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data_i[CB_RUN];
        os_q   <= wr_data_i[CB_OS];
        edge_q <= edge_sel_e'(wr_data_i[CB_EDGE +: 2]);
      end
      if (wr_per)  period_q <= wr_data_i;
      if (wr_duty) duty_q   <= wr_data_i;
      if (wr_out) begin
        octl_q.out_en   <= wr_data_i[OB_EN];
        octl_q.per_inv  <= wr_data_i[OB_PINV];
        octl_q.duty_inv <= wr_data_i[OB_DINV];
      end
      if (wr_irq) mask_q <= wr_data_i[IB_MASK];
      // a match in the same cycle as a clear keeps the flag set
      if (duty_hit_i)                          flag_q <= 1'b1;
      else if (wr_irq && wr_data_i[IB_FLAG])   flag_q <= 1'b0;
    end
  end

  // strobes use the enable held before this write (R9)
  assign lvl_set_o = wr_out && wr_data_i[OB_SET] && octl_q.out_en;
  assign lvl_clr_o = wr_out && wr_data_i[OB_CLR];
  assign os_trig_o = wr_out && wr_data_i[OB_TRIG] && os_q && run_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[CB_RUN]        = run_q;
        rd_data_o[CB_OS]         = os_q;
        rd_data_o[CB_EDGE +: 2]  = edge_q;
      end
      A_PERIOD: rd_data_o = period_q;
      A_DUTY:   rd_data_o = duty_q;
      A_OUTCTL: begin
        rd_data_o[OB_EN]   = octl_q.out_en;
        rd_data_o[OB_PINV] = octl_q.per_inv;
        rd_data_o[OB_DINV] = octl_q.duty_inv;
      end
      A_IRQ: begin
        rd_data_o[IB_MASK] = mask_q;
        rd_data_o[IB_FLAG] = flag_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign run_o       = run_q;
  assign os_mode_o   = os_q;
  assign edge_sel_o  = edge_q;
  assign period_o    = period_q;
  assign duty_o      = duty_q;
  assign octl_o      = octl_q;
  assign duty_mask_o = mask_q;

  // strobe bits never show on the read port (R6, R8)
  a_r8_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == A_OUTCTL) |-> (rd_data_o[OB_TRIG:OB_SET] == '0));
endmodule

// File: rtl/ppg_counter.sv
module ppg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             os_mode_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             os_trig_i,
  input  logic             duty_mask_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             per_hit_o,
  output logic             duty_hit_o,
  output logic             per_irq_o,
  output logic             duty_irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, per_irq_q, duty_irq_q;
  logic             active, step, per_hit, duty_hit;

  assign active   = run_i && (!os_mode_i || busy_q);
  assign step     = active && tick_i;
  assign per_hit  = step && (cnt_q == period_i);
  assign duty_hit = step && (cnt_q == duty_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      per_irq_q  <= 1'b0;
      duty_irq_q <= 1'b0;
    end else begin
      if (!run_i)       cnt_q <= '0;
      else if (per_hit) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + ONE;

      if (!run_i)         busy_q <= 1'b0;
      else if (os_trig_i) busy_q <= 1'b1;
      else if (per_hit)   busy_q <= 1'b0;

      per_irq_q  <= per_hit;
      duty_irq_q <= duty_hit && !duty_mask_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign per_hit_o  = per_hit;
  assign duty_hit_o = duty_hit;
  assign per_irq_o  = per_irq_q;
  assign duty_irq_o = duty_irq_q;

  a_r1_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_hit |=> (cnt_q == '0) && per_irq_q);
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(cnt_q));
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    duty_mask_i |=> !duty_irq_q);
  a_r6_idle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && os_mode_i && !busy_q) |=> $stable(cnt_q));
endmodule

// File: rtl/ppg_outff.sv
module ppg_outff
  import ppg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_ctl_t octl_i,
  input  logic     lvl_set_i,
  input  logic     lvl_clr_i,
  input  logic     per_hit_i,
  input  logic     duty_hit_i,
  output logic     ppg_o
);
  logic out_q, flip;

  // the two matches never coincide for legal settings; xor keeps it symmetric
  assign flip = (per_hit_i && octl_i.per_inv) ^ (duty_hit_i && octl_i.duty_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= 1'b0;
    else if (lvl_clr_i) out_q <= 1'b0;
    else if (lvl_set_i) out_q <= 1'b1;
    else if (flip)      out_q <= !out_q;
  end

  assign ppg_o = octl_i.out_en && out_q;

  a_r8_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_clr_i |=> !out_q);
  a_r8_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_set_i && !lvl_clr_i) |=> out_q);
  a_r4_no_stray_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_set_i && !lvl_clr_i && !per_hit_i && !(duty_hit_i && octl_i.duty_inv))
      |=> $stable(out_q));
endmodule

// File: rtl/ppg_edge.sv
module ppg_edge
  import ppg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  edge_sel_e edge_sel_i,
  input  logic      edge_in_i,
  output logic      edge_o
);
  logic pin_s;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign pin_s = edge_in_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else begin
          sh_q[0] <= edge_in_i;
          for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign pin_s = sh_q[SYNC_STAGES-1];
    end
  endgenerate

  // prev_q holds 0 until the first enable, so a pin already high reads as a rise
  logic seen_q, prev_q, edge_q, rise, fall, hit;

  assign rise = pin_s && !prev_q;
  assign fall = !pin_s && prev_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise || fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      seen_q <= seen_q || run_i;
      prev_q <= (seen_q || run_i) ? pin_s : 1'b0;
      edge_q <= run_i && hit;
    end
  end

  assign edge_o = edge_q;

  a_r10_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel_i == EDGE_OFF) |=> !edge_q);
  a_r11_stopped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !edge_q);
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ppg_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  input  logic [ppg_pkg::ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]          rd_data,
  input  logic                      cnt_tick_i,
  input  logic                      edge_in_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      ppg_o,
  output logic                      per_irq_o,
  output logic                      duty_irq_o,
  output logic                      edge_irq_o
);
  import ppg_pkg::*;

  logic             run, os_mode, duty_mask, lvl_set, lvl_clr, os_trig;
  logic             per_hit, duty_hit;
  edge_sel_e        edge_sel;
  logic [CNT_W-1:0] period, duty;
  out_ctl_t         octl;

  ppg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .duty_hit_i(duty_hit),
    .run_o(run), .os_mode_o(os_mode), .edge_sel_o(edge_sel),
    .period_o(period), .duty_o(duty), .octl_o(octl),
    .duty_mask_o(duty_mask),
    .lvl_set_o(lvl_set), .lvl_clr_o(lvl_clr), .os_trig_o(os_trig)
  );

  ppg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run_i(run), .os_mode_i(os_mode), .tick_i(cnt_tick_i),
    .period_i(period), .duty_i(duty), .os_trig_i(os_trig),
    .duty_mask_i(duty_mask),
    .cnt_o(cnt_o), .per_hit_o(per_hit), .duty_hit_o(duty_hit),
    .per_irq_o(per_irq_o), .duty_irq_o(duty_irq_o)
  );

  ppg_outff u_out (
    .clk(clk), .rst_n(rst_n), .octl_i(octl),
    .lvl_set_i(lvl_set), .lvl_clr_i(lvl_clr),
    .per_hit_i(per_hit), .duty_hit_i(duty_hit),
    .ppg_o(ppg_o)
  );

  ppg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .run_i(run), .edge_sel_i(edge_sel),
    .edge_in_i(edge_in_i), .edge_o(edge_irq_o)
  );

  // output follows the enable at the pin (R12)
  a_r12_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OUTCTL && !wr_data[OB_EN]) |=> !ppg_o);
endmodule

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          cnt_tick_i = 1'b1;
  logic          edge_in_i = 1'b0;
  logic [CW-1:0] cnt_o;
  logic          ppg_o, per_irq_o, duty_irq_o, edge_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tick_ph = 0;

  ppg_timer #(.CNT_W(CW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_tick_i(cnt_tick_i), .edge_in_i(edge_in_i), .cnt_o(cnt_o),
    .ppg_o(ppg_o), .per_irq_o(per_irq_o), .duty_irq_o(duty_irq_o),
    .edge_irq_o(edge_irq_o)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) cnt_tick_i <= 1'b1;
    else begin
      cnt_tick_i <= (tick_ph == 0);
      tick_ph    <= (tick_ph + 1) % tick_div;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic smp();
    @(posedge clk);
    #1;
  endtask

  // output control values
  localparam int O_EN = 1, O_PINV = 2, O_DINV = 4, O_SET = 8, O_CLR = 16, O_TRIG = 32;

  task automatic prime_high(input int ctl);
    wr(3'd3, ctl | O_CLR);
    wr(3'd3, ctl | O_SET);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 reset cnt", int'(cnt_o), 0);
    chk("R12 reset out", int'(ppg_o), 0);
    chk("R1 reset per_irq", int'(per_irq_o), 0);
    chk("R5 reset duty_irq", int'(duty_irq_o), 0);
    rd(3'd1, v); chk("R1 reset period", v, 255);
    rd(3'd2, v); chk("R2 reset duty", v, 0);
  endtask

  task automatic t_first_enable();
    int n = 0;
    wr(3'd0, 1 | (1 << 2));
    repeat (6) begin smp(); n += int'(edge_irq_o); end
    chk("R11 first enable with pin high", n, 1);
    wr(3'd0, 0);
    repeat (3) smp();
    n = 0;
    wr(3'd0, 1 | (1 << 2));
    repeat (6) begin smp(); n += int'(edge_irq_o); end
    chk("R11 re-enable with pin high", n, 0);
    wr(3'd0, 0);
    edge_in_i = 1'b0;
    repeat (4) smp();
  endtask

  task automatic t_periodic();
    int prev, exp, bad_seq = 0, bad_out = 0, bad_pirq = 0, bad_dirq = 0;
    int npirq = 0, ndirq = 0;
    wr(3'd1, 5); wr(3'd2, 2);
    prime_high(O_EN | O_PINV | O_DINV);
    wr(3'd0, 1);
    repeat (3) smp();
    prev = int'(cnt_o);
    for (int i = 0; i < 24; i++) begin
      smp();
      exp = (prev == 5) ? 0 : prev + 1;
      if (int'(cnt_o) != exp) bad_seq++;
      if (ppg_o != (cnt_o <= 2)) bad_out++;
      if (per_irq_o != (cnt_o == 0)) bad_pirq++;
      if (duty_irq_o != (cnt_o == 3)) bad_dirq++;
      npirq += int'(per_irq_o);
      ndirq += int'(duty_irq_o);
      prev = int'(cnt_o);
    end
    chk("R1 count sequence errors", bad_seq, 0);
    chk("R1 period pulses in 4 cycles", npirq, 4);
    chk("R1 period pulse placement errors", bad_pirq, 0);
    chk("R2 output shape errors", bad_out, 0);
    chk("R5 duty pulses in 4 cycles", ndirq, 4);
    chk("R5 duty pulse placement errors", bad_dirq, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_duty_zero();
    int nhigh = 0, bad = 0;
    wr(3'd2, 0);
    prime_high(O_EN | O_PINV | O_DINV);
    wr(3'd0, 1);
    repeat (3) smp();
    for (int i = 0; i < 12; i++) begin
      smp();
      nhigh += int'(ppg_o);
      if (ppg_o != (cnt_o == 0)) bad++;
    end
    chk("R2 duty zero high samples", nhigh, 2);
    chk("R2 duty zero shape errors", bad, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_full_range();
    int guard = 0, len = 0, nhigh = 0;
    wr(3'd1, 255); wr(3'd2, 127);
    prime_high(O_EN | O_PINV | O_DINV);
    wr(3'd0, 1);
    smp();
    while (!per_irq_o && guard < 600) begin smp(); guard++; end
    do begin
      nhigh += int'(ppg_o);
      smp(); len++;
    end while (!per_irq_o && len < 600);
    chk("R1 full-range cycle length", len, 256);
    chk("R2 full-range high time", nhigh, 128);
    wr(3'd0, 0);
  endtask

  task automatic t_tick_gate();
    int prev, exp, bad = 0, adv = 0;
    wr(3'd1, 5); wr(3'd2, 2);
    tick_div = 3;
    wr(3'd0, 1);
    smp();
    prev = int'(cnt_o);
    for (int i = 0; i < 30; i++) begin
      smp();
      if (cnt_tick_i) begin
        exp = (prev == 5) ? 0 : prev + 1;
        adv++;
      end else exp = prev;
      if (int'(cnt_o) != exp) bad++;
      prev = int'(cnt_o);
    end
    chk("R3 counter follows tick errors", bad, 0);
    chk("R3 advances in 30 clocks", adv, 10);
    wr(3'd0, 0);
    smp();
    chk("R3 stop clears counter", int'(cnt_o), 0);
    repeat (3) smp();
    chk("R3 stopped counter holds 0", int'(cnt_o), 0);
    tick_div = 1;
  endtask

  task automatic t_no_duty_toggle();
    int prevo, bad = 0, nd = 0;
    wr(3'd1, 5); wr(3'd2, 2);
    prime_high(O_EN | O_PINV);
    wr(3'd0, 1);
    repeat (3) smp();
    prevo = int'(ppg_o);
    for (int i = 0; i < 24; i++) begin
      smp();
      if ((int'(ppg_o) != prevo) != (cnt_o == 0)) bad++;
      nd += int'(duty_irq_o);
      prevo = int'(ppg_o);
    end
    chk("R4 output changes only at wrap, errors", bad, 0);
    chk("R5 duty pulses without toggling", nd, 4);
    wr(3'd0, 0);
  endtask

  task automatic t_mask();
    int nd = 0, v;
    wr(3'd4, 3);
    wr(3'd0, 1);
    repeat (12) begin smp(); nd += int'(duty_irq_o); end
    chk("R5 masked duty pulses", nd, 0);
    wr(3'd0, 0);
    rd(3'd4, v);
    chk("R5 flag set while masked", v, 3);
    wr(3'd4, 1 | 2);
    rd(3'd4, v);
    chk("R5 flag cleared by write", v, 1);
    wr(3'd4, 0);
  endtask

  task automatic t_oneshot();
    int moved = 0, np = 0, nlow = 0, v;
    wr(3'd1, 4); wr(3'd2, 1);
    prime_high(O_EN | O_PINV | O_DINV);
    wr(3'd0, 3);
    repeat (8) begin smp(); moved += (cnt_o != 0); np += int'(per_irq_o); end
    chk("R6 waits for trigger", moved + np, 0);
    wr(3'd3, O_EN | O_PINV | O_DINV | O_TRIG);
    moved = 0;
    for (int i = 0; i < 12; i++) begin
      smp();
      moved += (cnt_o != 0);
      np    += int'(per_irq_o);
      nlow  += int'(!ppg_o);
    end
    chk("R6 single pass nonzero counts", moved, 4);
    chk("R6 single period pulse", np, 1);
    chk("R6 low time in pass", nlow, 3);
    rd(3'd3, v);
    chk("R6 trigger reads zero", v, 7);
    wr(3'd0, 0);
  endtask

  task automatic t_trig_ignored();
    int v, moved = 0;
    wr(3'd1, 5);
    wr(3'd0, 1);
    wr(3'd3, O_EN | O_PINV | O_DINV | O_TRIG);
    wr(3'd0, 3);
    smp();
    v = int'(cnt_o);
    repeat (10) begin smp(); moved += (int'(cnt_o) != v); end
    chk("R7 trigger outside one-shot ignored", moved, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_levels();
    int v;
    wr(3'd3, O_EN | O_CLR);
    chk("R8 force low", int'(ppg_o), 0);
    wr(3'd3, 0);
    wr(3'd3, O_EN | O_SET);
    chk("R9 set with enable in same write", int'(ppg_o), 0);
    wr(3'd3, O_EN);
    chk("R9 flop stayed low", int'(ppg_o), 0);
    wr(3'd3, O_EN | O_SET);
    chk("R8 force high", int'(ppg_o), 1);
    rd(3'd3, v);
    chk("R8 strobes read zero", v, 1);
    wr(3'd3, 0);
    chk("R12 disabled output low", int'(ppg_o), 0);
    wr(3'd3, O_EN);
    chk("R12 state kept while disabled", int'(ppg_o), 1);
    wr(3'd3, O_EN | O_SET | O_CLR);
    chk("R8 force low has priority", int'(ppg_o), 0);
  endtask

  task automatic edge_run(input int sel, input int exp, input string req);
    int n = 0;
    wr(3'd0, 1 | (sel << 2));
    repeat (5) smp();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      edge_in_i = (k % 2 == 0);
      repeat (5) begin smp(); n += int'(edge_irq_o); end
    end
    chk(req, n, exp);
    wr(3'd0, 0);
  endtask

  task automatic t_edges();
    edge_run(1, 2, "R10 rising only");
    edge_run(2, 2, "R10 falling only");
    edge_run(3, 4, "R10 both edges");
    edge_run(0, 0, "R10 edges off");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    edge_in_i = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) smp();
    t_reset();
    t_first_enable();
    t_periodic();
    t_duty_zero();
    t_full_range();
    t_tick_gate();
    t_no_duty_toggle();
    t_mask();
    t_oneshot();
    t_trig_ignored();
    t_levels();
    t_edges();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule